// File: doc/BRIEF.md
# Interrupt Collector with Card Presence Detection

This block gathers the interrupt sources of a memory-card host bridge into one latched status word and drives a single active-low interrupt pin toward the host processor. Each status bit has a matching enable bit. A global enable bit gates the whole request. Reading the status word clears its latched bits. The pin is updated on the falling clock edge.

Two detectors report card insertion and removal. The first watches the card's data-line-3 pin. It is only trusted while the serial interface is disabled and no wide-bus transfer is driving that line. The second watches the pins of a five-bit general-purpose port, where one pin may be wired to a slot switch. Every port pin configured as an input has its own change status bit and its own enable bit. The OR of the port status feeds one summary bit of the main status word, so the two levels cascade. The synchronised live levels of both detectors are presented for status reads. Register decode and the logic that produces the other interrupt sources lie outside this block. The block receives their write data, enable strobes and event pulses.

Top module: `irqcd_top`

## Requirements
- R1: After hard reset (`rst` high, synchronous), the main status, the port status and both enable registers are zero, and `irq_n` is high.
- R2: A one-cycle pulse on `src_evt[k]` sets main status bit 2+k at the next rising edge. The bit stays set until it is cleared.
- R3: With `sif_en` low and `wide_busy` low, a rising or falling change of `dat3_in` sets main status bit 0 within four rising edges, after a 2-flop synchroniser. Changes in the first three cycles after reset are not reported.
- R4: A one-cycle `rd_ist` pulse clears all latched main status bits at the next edge. A one-cycle `rd_gist` pulse does the same for the port status.
- R5: If a set and a read-clear reach the same bit in the same cycle, the bit ends up set.
- R6: On each falling edge, `irq_n` is driven low when the global enable is set and any status bit is set together with its enable. Otherwise it is driven high.
- R7: While `sif_en` or `wide_busy` is high, `dat3_in` changes do not set bit 0. A level change made during that time is not reported after it ends.
- R8: `cd_level` and `gio_level` show the synchronised levels of `dat3_in` and `gpio_in`.
- R9: A change on `gpio_in[i]` sets `gist_q[i]` only when `gpio_oe[i]` is 0 and port enable bit i is 1.
- R10: Main status bit 1 is the OR of `gist_q`. It stays set through a `rd_ist` read while any port status bit is set.
- R11: `soft_rst` clears both status words but keeps both enable registers.
- R12: Writing with `en_we` loads `en_wdata`: bit 5 is the global enable and bits 4:0 enable main status bits 4:0. Writing with `gen_we` loads the per-pin port enables from `gen_wdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous hard reset, active high |
| soft_rst | input | 1 | Software reset pulse; clears status only |
| src_evt | input | 3 | Event pulses from other interrupt sources |
| dat3_in | input | 1 | Card data-line-3 level, asynchronous |
| sif_en | input | 1 | Serial interface enabled; blocks data-line-3 detection |
| wide_busy | input | 1 | Wide-bus transfer currently drives data line 3 |
| gpio_in | input | 5 | General port pin levels, asynchronous |
| gpio_oe | input | 5 | Per-pin output enable (1 = output) |
| en_we | input | 1 | Write strobe for the main enable register |
| en_wdata | input | 6 | Main enable data, bit 5 global |
| gen_we | input | 1 | Write strobe for the port enable register |
| gen_wdata | input | 5 | Port per-pin enable data |
| rd_ist | input | 1 | Main status read, clears latched bits |
| rd_gist | input | 1 | Port status read, clears the bits |
| irq_n | output | 1 | Interrupt request, active low, falling-edge timed |
| ist_q | output | 5 | Main status word |
| gist_q | output | 5 | Port status word |
| cd_level | output | 1 | Synchronised data-line-3 level |
| gio_level | output | 5 | Synchronised port levels |

## Verification
The assertions check several rules on every cycle. A set wins over a clear, and a clear empties the bits it targets. The pin stays high while the global enable is off. The summary bit follows any nonzero port status. Bit 0 never rises while data line 3 is blocked, and a port bit never rises for an output pin or a disabled pin. Other behaviour can only be shown by the bench's scenarios, because it depends on sequence. Examples are the synchroniser latency, the absence of a late report after a blocked period ends, the summary bit surviving a main read, and a soft reset keeping the enables.

// File: rtl/irqcd_pkg.sv
package irqcd_pkg;

    localparam int unsigned IDX_CD    = 0;
    localparam int unsigned IDX_GP    = 1;
    localparam int unsigned IDX_EXT   = 2;
    localparam int unsigned WARM_MAX  = 3;
    localparam int unsigned WARM_BITS = $clog2(WARM_MAX + 1);

    typedef struct packed {
        logic sif_en;
        logic wide_busy;
    } dl3_ctx_t;

    typedef enum logic {
        PIN_ASSERT = 1'b0,
        PIN_IDLE   = 1'b1
    } pin_lvl_t;

    function automatic logic dl3_edge_ok(input logic tog, input dl3_ctx_t ctx);
        return tog & ~ctx.sif_en & ~ctx.wide_busy;
    endfunction

endpackage

// File: rtl/irqcd_sync_edge.sv
module irqcd_sync_edge
    import irqcd_pkg::*;
#(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] level,
    output logic [W-1:0] toggled
);

    logic [W-1:0] stage1;
    logic [W-1:0] stage2;
    logic [W-1:0] prev;
    logic [WARM_BITS-1:0] warm;
    logic armed;

    assign armed = (warm == WARM_BITS'(WARM_MAX));

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
            prev   <= '0;
            warm   <= '0;
        end else begin
            stage1 <= din;
            stage2 <= stage1;
            prev   <= stage2;
            if (!armed) warm <= warm + 1'b1;
        end
    end

    assign level   = stage2;
    assign toggled = (stage2 ^ prev) & {W{armed}};

endmodule

// File: rtl/irqcd_sticky.sv
module irqcd_sticky #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr) | set;
    end

    // R5: a set in the same cycle as a clear survives
    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (set != '0) |=> ((q & $past(set)) == $past(set)));

    // R4: cleared bits with no concurrent set are zero afterwards
    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        ((clr & ~set) != '0) |=> ((q & $past(clr & ~set)) == '0));

endmodule

// File: rtl/irqcd_pin_drv.sv
module irqcd_pin_drv
    import irqcd_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] stat,
    input  logic [W-1:0] en,
    input  logic         glob,
    output logic         irq_n
);

    logic pend;

    assign pend = glob & (|(stat & en));

    always_ff @(negedge clk) begin
        if (rst) irq_n <= PIN_IDLE;
        else     irq_n <= pend ? PIN_ASSERT : PIN_IDLE;
    end

endmodule

// File: rtl/irqcd_top.sv
module irqcd_top
    import irqcd_pkg::*;
#(
    parameter int unsigned N_EXT = 3,
    parameter int unsigned GW    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic [N_EXT-1:0]  src_evt,
    input  logic              dat3_in,
    input  logic              sif_en,
    input  logic              wide_busy,
    input  logic [GW-1:0]     gpio_in,
    input  logic [GW-1:0]     gpio_oe,
    input  logic              en_we,
    input  logic [N_EXT+2:0]  en_wdata,
    input  logic              gen_we,
    input  logic [GW-1:0]     gen_wdata,
    input  logic              rd_ist,
    input  logic              rd_gist,
    output logic              irq_n,
    output logic [N_EXT+1:0]  ist_q,
    output logic [GW-1:0]     gist_q,
    output logic              cd_level,
    output logic [GW-1:0]     gio_level
);

    localparam int unsigned NS = N_EXT + IDX_EXT;

    logic [NS:0]    en_q;
    logic [GW-1:0]  gen_q;
    logic           cd_tog;
    logic [GW-1:0]  gio_tog;
    logic           cd_set;
    logic [GW-1:0]  gp_set;
    logic [NS-1:0]  main_set;
    logic [NS-1:0]  main_lat;
    dl3_ctx_t       ctx;

    // enable registers: hard reset only
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            gen_q <= '0;
        end else begin
            if (en_we)  en_q  <= en_wdata;
            if (gen_we) gen_q <= gen_wdata;
        end
    end

    irqcd_sync_edge #(.W(1)) u_cd_sync (
        .clk     (clk),
        .rst     (rst),
        .din     (dat3_in),
        .level   (cd_level),
        .toggled (cd_tog)
    );

    irqcd_sync_edge #(.W(GW)) u_gio_sync (
        .clk     (clk),
        .rst     (rst),
        .din     (gpio_in),
        .level   (gio_level),
        .toggled (gio_tog)
    );

    assign ctx.sif_en    = sif_en;
    assign ctx.wide_busy = wide_busy;
    assign cd_set        = dl3_edge_ok(cd_tog, ctx);

    genvar gi;
    generate
        for (gi = 0; gi < GW; gi++) begin : g_pin
            assign gp_set[gi] = gio_tog[gi] & ~gpio_oe[gi] & gen_q[gi];
        end
    endgenerate

    irqcd_sticky #(.W(GW)) u_gstat (
        .clk (clk),
        .rst (rst),
        .set (gp_set),
        .clr ({GW{rd_gist | soft_rst}}),
        .q   (gist_q)
    );

    assign main_set = {src_evt, 1'b0, cd_set};

    irqcd_sticky #(.W(NS)) u_mstat (
        .clk (clk),
        .rst (rst),
        .set (main_set),
        .clr ({NS{rd_ist | soft_rst}}),
        .q   (main_lat)
    );

    always_comb begin
        ist_q         = main_lat;
        ist_q[IDX_GP] = |gist_q;
    end

    irqcd_pin_drv #(.W(NS)) u_pin (
        .clk   (clk),
        .rst   (rst),
        .stat  (ist_q),
        .en    (en_q[NS-1:0]),
        .glob  (en_q[NS]),
        .irq_n (irq_n)
    );

    // R6: no request while the global enable is off
    p_irq_gate_r6: assert property (@(posedge clk) disable iff (rst)
        !en_q[NS] |-> irq_n);

    // R10: any port status shows up in the summary bit
    p_sum_r10: assert property (@(posedge clk) disable iff (rst)
        (gist_q != '0) |-> ist_q[IDX_GP]);

    // R7: data-line-3 detection quiet while blocked
    p_dl3_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(sif_en || wide_busy) && !$past(ist_q[IDX_CD])) |-> !ist_q[IDX_CD]);

    // R9: output pins and disabled pins never raise port status
    p_pin_gate_r9: assert property (@(posedge clk) disable iff (rst)
        ((gist_q & ~$past(gist_q) & $past(gpio_oe | ~gen_q)) == '0));

endmodule

// File: tb/irqcd_top_tb.sv
`timescale 1ns/1ps
module irqcd_top_tb;

    localparam int N_EXT = 3;
    localparam int GW    = 5;
    localparam int NS    = N_EXT + 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic soft_rst = 1'b0;
    logic [N_EXT-1:0] src_evt = '0;
    logic dat3_in = 1'b0;
    logic sif_en = 1'b0;
    logic wide_busy = 1'b0;
    logic [GW-1:0] gpio_in = '0;
    logic [GW-1:0] gpio_oe = '0;
    logic en_we = 1'b0;
    logic [NS:0] en_wdata = '0;
    logic gen_we = 1'b0;
    logic [GW-1:0] gen_wdata = '0;
    logic rd_ist = 1'b0;
    logic rd_gist = 1'b0;
    logic irq_n;
    logic [NS-1:0] ist_q;
    logic [GW-1:0] gist_q;
    logic cd_level;
    logic [GW-1:0] gio_level;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irqcd_top #(.N_EXT(N_EXT), .GW(GW)) u_dut (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .src_evt(src_evt),
        .dat3_in(dat3_in), .sif_en(sif_en), .wide_busy(wide_busy),
        .gpio_in(gpio_in), .gpio_oe(gpio_oe), .en_we(en_we), .en_wdata(en_wdata),
        .gen_we(gen_we), .gen_wdata(gen_wdata), .rd_ist(rd_ist), .rd_gist(rd_gist),
        .irq_n(irq_n), .ist_q(ist_q), .gist_q(gist_q),
        .cd_level(cd_level), .gio_level(gio_level)
    );

    typedef struct {
        string          tag;
        logic [NS-1:0]  ist;
        logic [GW-1:0]  gist;
        logic           irq;
    } exp_t;

    exp_t sb_q[$];

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // monitor: compare outputs after the falling edge
    initial begin
        forever begin
            exp_t e;
            @(negedge clk);
            #1;
            if (sb_q.size() != 0) begin
                e = sb_q.pop_front();
                check(e.tag, "ist_q", int'(ist_q), int'(e.ist));
                check(e.tag, "gist_q", int'(gist_q), int'(e.gist));
                check(e.tag, "irq_n", int'(irq_n), int'(e.irq));
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_out(string tag, logic [NS-1:0] i, logic [GW-1:0] g, logic irq);
        exp_t e;
        e.tag = tag; e.ist = i; e.gist = g; e.irq = irq;
        sb_q.push_back(e);
        wait (sb_q.size() == 0);
    endtask

    task automatic wr_en(logic [NS:0] v);
        en_wdata = v; en_we = 1'b1; tick(1); en_we = 1'b0;
    endtask

    task automatic wr_gen(logic [GW-1:0] v);
        gen_wdata = v; gen_we = 1'b1; tick(1); gen_we = 1'b0;
    endtask

    task automatic read_main();
        rd_ist = 1'b1; tick(1); rd_ist = 1'b0;
    endtask

    task automatic read_port();
        rd_gist = 1'b1; tick(1); rd_gist = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        check("WDOG", "watchdog", 1, 0);
        finish_run();
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(4);
        expect_out("R1", 5'b00000, 5'b00000, 1'b1);

        // R12: global (bit 5) + data-line-3 enable (bit 0)
        wr_en(6'b100001);
        dat3_in = 1'b1; tick(4);
        expect_out("R3", 5'b00001, 5'b00000, 1'b0);
        check("R8", "cd_level", int'(cd_level), 1);
        read_main();
        expect_out("R4", 5'b00000, 5'b00000, 1'b1);

        // R6: global off masks the pin, status still latches
        wr_en(6'b000001);
        dat3_in = 1'b0; tick(4);
        expect_out("R6", 5'b00001, 5'b00000, 1'b1);
        read_main();
        wr_en(6'b100001);
        expect_out("R12", 5'b00000, 5'b00000, 1'b1);

        // R7: blocked by serial interface, and by wide transfer
        sif_en = 1'b1; dat3_in = 1'b1; tick(5);
        expect_out("R7", 5'b00000, 5'b00000, 1'b1);
        sif_en = 1'b0; tick(4);
        expect_out("R7", 5'b00000, 5'b00000, 1'b1);
        wide_busy = 1'b1; dat3_in = 1'b0; tick(5);
        wide_busy = 1'b0; tick(4);
        expect_out("R7", 5'b00000, 5'b00000, 1'b1);
        check("R8", "cd_level", int'(cd_level), 0);

        // port path: global + summary enable
        wr_en(6'b100010);
        wr_gen(5'b00001);
        gpio_oe = 5'b00001; gpio_in = 5'b00001; tick(5);
        expect_out("R9", 5'b00000, 5'b00000, 1'b1);
        check("R8", "gio_level", int'(gio_level), 1);
        gpio_oe = 5'b00000; gpio_in = 5'b00000; tick(4);
        expect_out("R9", 5'b00010, 5'b00001, 1'b0);
        gpio_in = 5'b00100; tick(5);
        expect_out("R9", 5'b00010, 5'b00001, 1'b0);
        check("R8", "gio_level", int'(gio_level), 4);
        read_main();
        expect_out("R10", 5'b00010, 5'b00001, 1'b0);
        read_port();
        expect_out("R4", 5'b00000, 5'b00000, 1'b1);

        // external sources
        wr_en(6'b111100);
        src_evt = 3'b010; tick(1); src_evt = 3'b000;
        expect_out("R2", 5'b01000, 5'b00000, 1'b0);
        src_evt = 3'b001; rd_ist = 1'b1; tick(1);
        src_evt = 3'b000; rd_ist = 1'b0;
        expect_out("R5", 5'b00100, 5'b00000, 1'b0);

        // soft reset keeps enables
        soft_rst = 1'b1; tick(1); soft_rst = 1'b0;
        expect_out("R11", 5'b00000, 5'b00000, 1'b1);
        src_evt = 3'b100; tick(1); src_evt = 3'b000;
        expect_out("R11", 5'b10000, 5'b00000, 1'b0);

        // hard reset clears enables
        rst = 1'b1; tick(2); rst = 1'b0; tick(1);
        src_evt = 3'b100; tick(1); src_evt = 3'b000;
        expect_out("R1", 5'b10000, 5'b00000, 1'b1);

        tick(2);
        finish_run();
    end

endmodule